// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Transceiver

This block is a full-duplex UART-style serial port that sits on a narrow 8-bit register bus. It sends and receives characters of 8 or 9 data bits, least significant bit first, framed by one start bit and one stop bit. One data address is used in both directions. A write to it fills a transmit buffer, and a read from it returns a separate receive buffer. The transmit side is double-buffered: the next character can be written while the current one is still being shifted out.

A divisor register sets the bit rate. The receiver oversamples the line at 16 times the bit rate. It confirms a start bit at the middle of that bit and then takes each later bit at its centre. Status bits report the following:
- the transmit buffer is empty;
- the transmitter is idle;
- a received character is waiting;
- an overrun occurred;
- a framing error occurred.

A synchronous clock output pulses once per transmitted data bit. Its idle level, its phase and whether the last data bit gets a pulse are all programmable. This lets a clocked peripheral latch the transmitted data.

Register map (3-bit address): 0 data, 1 control A, 2 control B, 3 status, 4 divisor.

Top module: `sci_xcvr`

## Requirements
- R1: After reset, status (address 3) reads 0xC0 (bit 7 transmit buffer empty, bit 6 transmitter idle). Control A and control B (addresses 1, 2) read 0x00, `txd_o` is high and `sclk_o` is low.
- R2: A write to address 0 loads the transmit buffer. A read of address 0 returns the receive buffer. A write never alters the value read back.
- R3: A transmitted character is one low start bit, then the data bits least significant first, then one high stop bit. `txd_o` stays high whenever the transmitter is idle.
- R4: Control A bit 4 set selects 9 data bits. Control A bit 6 is sent as the ninth data bit. A received ninth bit appears in control A bit 7.
- R5: Status bit 7 clears on a write to address 0. It sets when the buffer moves into the shifter. That move happens only while control B bit 3 (transmit enable) is set and only after the character in the shifter has fully gone out, so characters written back to back are sent in order.
- R6: With control B bit 2 (receive enable) set, a completed character is placed in the receive buffer and status bit 5 sets.
- R7: Status bit 5 clears only when a status read that sees it set is followed by a data read. A data read alone leaves it set.
- R8: If a character completes while status bit 5 is still set, status bit 3 sets and the receive buffer keeps the earlier character. The R7 sequence clears bit 3.
- R9: A stop bit sampled low sets status bit 1. The R7 sequence clears it.
- R10: One bit lasts 16 × (divisor + 1) clock cycles for both transmit and receive.
- R11: Control A bit 2 sets the idle level of `sclk_o`. `sclk_o` leaves that level only during transmitted data bits.
- R12: With control A bit 1 clear, each clock pulse begins at the middle of its data bit. With bit 1 set, it begins at the start of the bit and ends at the middle.
- R13: With control A bit 0 set, every data bit gets one pulse. With it clear, the last data bit gets none.
- R14: A low level on `rxd_i` that is gone before the middle of a start bit is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives the flag-clear sequence) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| sclk_o | output | 1 | Synchronous clock output for transmitted data |

## Verification
The assertions check on every cycle the following:
- the transmit line is high whenever the transmitter is idle;
- the clock output holds its idle level outside a character;
- a data write always empties the transmit-empty flag, and that flag can only rise while transmit is enabled;
- a completed character always sets the receive-full flag;
- an overrun never disturbs the stored character.

Only the directed scenarios can show the frame contents and bit order, the ninth-bit paths, the exact bit period, the number and phase of clock pulses, the order of the flag-clear sequence, framing errors and start-glitch rejection. Those scenarios decode or drive whole serial frames.

// File: rtl/sci_pkg.sv
`timescale 1ns/1ps
package sci_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTLA = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTLB = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  typedef struct packed {
    logic t8;
    logic m;
    logic wake;
    logic cpol;
    logic cpha;
    logic lbcl;
  } frame_cfg_t;
endpackage

// File: rtl/sci_baud.sv
`timescale 1ns/1ps
module sci_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sci_tx.sv
`timescale 1ns/1ps
module sci_tx import sci_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       pend_i,
  input  logic [7:0] data_i,
  input  frame_cfg_t cfg_i,
  output logic       load_o,
  output logic       busy_o,
  output logic       txd_o,
  output logic       sclk_o
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(OVS / 2);

  logic [PH_W-1:0] ph_q;
  logic [9:0]      sh_q;
  logic [3:0]      left_q, pos_q, nd;
  logic            busy_q, txd_q, sclk_q, m_q;
  logic            strobe, free;
  logic            in_data, active, pulse, sclk_d;

  // free-running bit phase: transfers align to the bit clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (tick_i) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  assign strobe = tick_i && (ph_q == PH_LAST);
  assign free   = !busy_q || (left_q == 4'd0);
  assign load_o = strobe && free && en_i && pend_i;
  assign nd     = m_q ? 4'd9 : 4'd8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '1;
      left_q <= '0;
      pos_q  <= '0;
      m_q    <= 1'b0;
    end else if (strobe) begin
      if (!free) begin
        txd_q  <= sh_q[0];
        sh_q   <= {1'b1, sh_q[9:1]};
        left_q <= left_q - 1'b1;
        pos_q  <= pos_q + 1'b1;
      end else if (en_i && pend_i) begin
        txd_q  <= 1'b0;
        sh_q   <= cfg_i.m ? {1'b1, cfg_i.t8, data_i} : {2'b11, data_i};
        left_q <= cfg_i.m ? 4'd10 : 4'd9;
        pos_q  <= '0;
        busy_q <= 1'b1;
        m_q    <= cfg_i.m;
      end else begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    in_data = busy_q && (pos_q != 4'd0) && (pos_q <= nd);
    active  = in_data && (cfg_i.lbcl || (pos_q != nd));
    pulse   = cfg_i.cpha ? (ph_q < PH_HALF) : (ph_q >= PH_HALF);
    sclk_d  = cfg_i.cpol ^ (active && pulse);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_d;
  end

  assign busy_o = busy_q;
  assign txd_o  = txd_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/sci_rx.sv
`timescale 1ns/1ps
module sci_rx import sci_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       rxd_i,
  input  logic       m_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       ninth_o,
  output logic       stop_ok_o
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] MID  = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

  rx_state_e       st_q;
  logic [1:0]      sync_q;
  logic [PH_W-1:0] tcnt_q;
  logic [3:0]      bitn_q, nd;
  logic [8:0]      sh_q;
  logic            done_q, stop_q, rxs;

  assign rxs = sync_q[1];
  assign nd  = m_i ? 4'd9 : 4'd8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else if (tick_i) begin
        case (st_q)
          RX_IDLE: if (!rxs) begin
            st_q   <= RX_START;
            tcnt_q <= '0;
          end
          RX_START: if (tcnt_q == MID) begin
            tcnt_q <= '0;
            bitn_q <= '0;
            st_q   <= rxs ? RX_IDLE : RX_DATA;  // reject short glitches
          end else tcnt_q <= tcnt_q + 1'b1;
          RX_DATA: if (tcnt_q == LAST) begin
            tcnt_q <= '0;
            sh_q   <= {rxs, sh_q[8:1]};
            bitn_q <= bitn_q + 1'b1;
            if (bitn_q == nd - 4'd1) st_q <= RX_STOP;
          end else tcnt_q <= tcnt_q + 1'b1;
          RX_STOP: if (tcnt_q == LAST) begin
            done_q <= 1'b1;
            stop_q <= rxs;
            st_q   <= RX_IDLE;
          end else tcnt_q <= tcnt_q + 1'b1;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign stop_ok_o = stop_q;
  assign data_o    = m_i ? sh_q[7:0] : sh_q[8:1];
  assign ninth_o   = m_i & sh_q[8];
endmodule

// File: rtl/sci_xcvr.sv
`timescale 1ns/1ps
module sci_xcvr import sci_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              sclk_o
);
  frame_cfg_t       cfg;
  logic             r8, tx_en, rx_en;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       tdr, rdr;
  logic             tx_empty, rx_full, ovr, fe, armed;
  logic             tick, tx_load, tx_busy, pend;
  logic             rx_done, rx_ninth, rx_stop_ok;
  logic [7:0]       rx_data;
  logic             wr_data, rd_data, rd_stat, clr, full_eff, cpol;

  assign wr_data  = wr_i && (addr_i == A_DATA);
  assign rd_data  = rd_i && (addr_i == A_DATA);
  assign rd_stat  = rd_i && (addr_i == A_STAT);
  assign clr      = rd_data && armed;
  assign full_eff = rx_full && !clr;
  assign pend     = !tx_empty && !wr_data;
  assign cpol     = cfg.cpol;

  sci_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i), .rst_ni(rst_ni), .div_i(div_q), .tick_o(tick)
  );

  sci_tx #(.OVS(OVS)) u_tx (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(tx_en),
    .pend_i(pend), .data_i(tdr), .cfg_i(cfg), .load_o(tx_load),
    .busy_o(tx_busy), .txd_o(txd_o), .sclk_o(sclk_o)
  );

  sci_rx #(.OVS(OVS)) u_rx (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(rx_en),
    .rxd_i (rxd_i), .m_i(cfg.m), .done_o(rx_done), .data_o(rx_data),
    .ninth_o(rx_ninth), .stop_ok_o(rx_stop_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg   <= '0;
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      div_q <= '0;
      tdr   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_DATA: tdr <= wdata_i;
        A_CTLA: begin
          cfg.t8   <= wdata_i[6];
          cfg.m    <= wdata_i[4];
          cfg.wake <= wdata_i[3];
          cfg.cpol <= wdata_i[2];
          cfg.cpha <= wdata_i[1];
          cfg.lbcl <= wdata_i[0];
        end
        A_CTLB: begin
          tx_en <= wdata_i[3];
          rx_en <= wdata_i[2];
        end
        A_DIV:  div_q <= DIV_W'(wdata_i);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_empty <= 1'b1;
    else if (wr_data) tx_empty <= 1'b0;
    else if (tx_load) tx_empty <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr     <= '0;
      r8      <= 1'b0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      fe      <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (clr) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
        fe      <= 1'b0;
        armed   <= 1'b0;
      end else if (rd_stat && rx_full) begin
        armed <= 1'b1;
      end
      if (rx_done) begin
        if (full_eff) ovr <= 1'b1;
        else begin
          rdr     <= rx_data;
          r8      <= rx_ninth;
          rx_full <= 1'b1;
        end
        if (!rx_stop_ok) fe <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = rdr;
      A_CTLA:  rdata_o = {r8, cfg.t8, 1'b0, cfg.m, cfg.wake, cfg.cpol, cfg.cpha, cfg.lbcl};
      A_CTLB:  rdata_o = {4'b0, tx_en, rx_en, 2'b0};
      A_STAT:  rdata_o = {tx_empty, !tx_busy, rx_full, 1'b0, ovr, 1'b0, fe, 1'b0};
      A_DIV:   rdata_o = 8'(div_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sci_chk.sv
`timescale 1ns/1ps
module sci_chk import sci_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              tx_en,
  input logic              tx_empty,
  input logic              tx_busy,
  input logic              txd_o,
  input logic              sclk_o,
  input logic              cpol,
  input logic              rx_done,
  input logic              rx_full,
  input logic [7:0]        rdr,
  input logic              ovr
);
  p_line_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  p_sclk_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy && $past(!tx_busy) && $stable(cpol)) |-> (sclk_o == cpol));

  p_empty_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DATA) |=> !tx_empty);

  p_load_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty) |-> $past(tx_en));

  p_full_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && !rx_full) |=> rx_full);

  p_overrun_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr) |-> $stable(rdr));
endmodule

bind sci_xcvr sci_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .tx_en(tx_en), .tx_empty(tx_empty), .tx_busy(tx_busy), .txd_o(txd_o),
  .sclk_o(sclk_o), .cpol(cpol), .rx_done(rx_done), .rx_full(rx_full),
  .rdr(rdr), .ovr(ovr)
);

// File: tb/sim_sci_xcvr.sv
`timescale 1ns/1ps
module sim_sci_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, sclk;

  int   checks = 0, failures = 0;
  int   bitc = 32;
  logic cpol_b = 1'b0;

  always #2 clk = ~clk;

  sci_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .sclk_o(sclk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_rx(input logic [8:0] v, input int nd, input bit stop_hi);
    @(negedge clk); rxd = 1'b0; repeat (bitc) @(negedge clk);
    for (int i = 0; i < nd; i++) begin rxd = v[i]; repeat (bitc) @(negedge clk); end
    if (stop_hi) begin rxd = 1'b1; repeat (bitc) @(negedge clk); end
    else begin rxd = 1'b0; repeat (bitc/2 + 4) @(negedge clk); rxd = 1'b1; end
    repeat (bitc) @(negedge clk);
  endtask

  task automatic cap_tx(input int nd, output logic [8:0] v, output logic stop,
                        output int pulses, output logic q);
    logic prev, cur;
    v = '0; stop = 1'b0; pulses = 0; q = 1'bx;
    while (txd !== 1'b0) @(negedge clk);
    prev = sclk ^ cpol_b;
    for (int t = 1; t <= bitc/2 + bitc*(nd+1); t++) begin
      @(negedge clk);
      cur = sclk ^ cpol_b;
      if (cur && !prev) pulses++;
      prev = cur;
      if (t == bitc + bitc/4) q = sclk;
      if (t >= bitc/2 + bitc && ((t - bitc/2) % bitc) == 0) begin
        if ((t - bitc/2)/bitc <= nd) v[(t - bitc/2)/bitc - 1] = txd;
        else stop = txd;
      end
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(3'd3, d); chk("R1 status", d, 8'hC0);
    rd_reg(3'd1, d); chk("R1 ctla", d, 8'h00);
    rd_reg(3'd2, d); chk("R1 ctlb", d, 8'h00);
    chk("R1 txd", txd, 1'b1);
    chk("R1 sclk", sclk, 1'b0);
  endtask

  task automatic t_tx_basic;
    logic [8:0] v; logic st, q; int p; logic [7:0] d;
    wr_reg(3'd1, 8'h01);
    wr_reg(3'd0, 8'hA5);
    rd_reg(3'd3, d); chk("R5 empty cleared", d[7], 1'b0);
    rd_reg(3'd0, d); chk("R2 rx buffer untouched", d, 8'h00);
    cap_tx(8, v, st, p, q);
    chk("R3 data lsb first", v[7:0], 8'hA5);
    chk("R3 stop", st, 1'b1);
    chk("R13 pulses lbcl=1", p, 8);
    chk("R12 cpha0 quarter", q, 1'b0);
  endtask

  task automatic t_tx_nine;
    logic [8:0] v; logic st, q; int p;
    wr_reg(3'd1, 8'h52);
    wr_reg(3'd0, 8'h3C);
    cap_tx(9, v, st, p, q);
    chk("R4 ninth tx", v, 9'h13C);
    chk("R3 stop 9bit", st, 1'b1);
    chk("R13 pulses lbcl=0", p, 8);
    chk("R12 cpha1 quarter", q, 1'b1);
    wr_reg(3'd1, 8'h00);
  endtask

  task automatic t_sclk_pol;
    logic [8:0] v; logic st, q; int p;
    wr_reg(3'd1, 8'h04);
    repeat (4) @(negedge clk);
    chk("R11 idle high", sclk, 1'b1);
    cpol_b = 1'b1;
    wr_reg(3'd0, 8'h0F);
    cap_tx(8, v, st, p, q);
    chk("R11 data cpol1", v[7:0], 8'h0F);
    chk("R13 pulses cpol1", p, 7);
    repeat (bitc) @(negedge clk);
    chk("R11 idle after frame", sclk, 1'b1);
    wr_reg(3'd1, 8'h00);
    cpol_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_tx_b2b;
    logic [8:0] va, vb; logic sa, sb, q; int p; logic [7:0] s;
    fork
      begin cap_tx(8, va, sa, p, q); cap_tx(8, vb, sb, p, q); end
      begin
        wr_reg(3'd0, 8'h5E);
        do rd_reg(3'd3, s); while (!s[7]);
        wr_reg(3'd0, 8'hC1);
        rd_reg(3'd3, s); chk("R5 second write pending", s[7], 1'b0);
      end
    join
    chk("R5 first char", va[7:0], 8'h5E);
    chk("R5 second char", vb[7:0], 8'hC1);
  endtask

  task automatic t_tx_gate;
    logic [8:0] v; logic st, q; int p; logic [7:0] s; bit low;
    repeat (bitc) @(negedge clk);
    wr_reg(3'd2, 8'h04);
    wr_reg(3'd0, 8'h81);
    low = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!txd) low = 1; end
    chk("R5 no send while disabled", low, 1'b0);
    rd_reg(3'd3, s); chk("R5 still full", s[7], 1'b0);
    fork
      cap_tx(8, v, st, p, q);
      wr_reg(3'd2, 8'h0C);
    join
    chk("R5 sent after enable", v[7:0], 8'h81);
  endtask

  task automatic t_rx_basic;
    logic [7:0] s, d;
    send_rx(9'h096, 8, 1);
    rd_reg(3'd3, s); chk("R6 full set", s[5], 1'b1); chk("R9 no framing", s[1], 1'b0);
    rd_reg(3'd0, d); chk("R6 data", d, 8'h96);
    rd_reg(3'd3, s); chk("R7 cleared", s[5], 1'b0);
  endtask

  task automatic t_rx_order;
    logic [7:0] s, d;
    send_rx(9'h03A, 8, 1);
    rd_reg(3'd0, d); chk("R2 read rx buffer", d, 8'h3A);
    rd_reg(3'd3, s); chk("R7 data-only read keeps flag", s[5], 1'b1);
    rd_reg(3'd0, d);
    rd_reg(3'd3, s); chk("R7 sequence clears", s[5], 1'b0);
  endtask

  task automatic t_rx_nine;
    logic [7:0] s, d, c;
    wr_reg(3'd1, 8'h10);
    send_rx(9'h15A, 9, 1);
    rd_reg(3'd1, c); chk("R4 ninth rx", c[7], 1'b1);
    rd_reg(3'd3, s);
    rd_reg(3'd0, d); chk("R4 data 9bit", d, 8'h5A);
    send_rx(9'h0A5, 9, 1);
    rd_reg(3'd1, c); chk("R4 ninth rx zero", c[7], 1'b0);
    rd_reg(3'd3, s); rd_reg(3'd0, d);
    wr_reg(3'd1, 8'h00);
  endtask

  task automatic t_overrun;
    logic [7:0] s, d;
    send_rx(9'h011, 8, 1);
    send_rx(9'h022, 8, 1);
    rd_reg(3'd3, s); chk("R8 overrun set", s[3], 1'b1);
    rd_reg(3'd0, d); chk("R8 buffer kept", d, 8'h11);
    rd_reg(3'd3, s); chk("R8 overrun cleared", s[3], 1'b0);
  endtask

  task automatic t_framing;
    logic [7:0] s, d;
    send_rx(9'h055, 8, 0);
    repeat (bitc) @(negedge clk);
    rd_reg(3'd3, s); chk("R9 framing set", s[1], 1'b1);
    rd_reg(3'd0, d); chk("R9 data", d, 8'h55);
    rd_reg(3'd3, s); chk("R9 framing cleared", s[1], 1'b0);
    chk("R14 no ghost char", s[5], 1'b0);
  endtask

  task automatic t_glitch;
    logic [7:0] s;
    @(negedge clk); rxd = 1'b0;
    repeat (bitc/4) @(negedge clk);
    rxd = 1'b1;
    repeat (bitc*12) @(negedge clk);
    rd_reg(3'd3, s); chk("R14 glitch ignored", s[5], 1'b0);
  endtask

  task automatic t_rate;
    logic [7:0] s, d; int n;
    wr_reg(3'd4, 8'd3);
    bitc = 64;
    repeat (40) @(negedge clk);
    wr_reg(3'd0, 8'h00);
    while (txd !== 1'b0) @(negedge clk);
    n = 0;
    while (txd === 1'b0) begin n++; @(negedge clk); end
    chk("R10 tx low span", (n >= 575 && n <= 577), 1'b1);
    repeat (bitc*2) @(negedge clk);
    send_rx(9'h0C3, 8, 1);
    rd_reg(3'd3, s); chk("R10 rx full", s[5], 1'b1);
    rd_reg(3'd0, d); chk("R10 rx data", d, 8'hC3);
    wr_reg(3'd4, 8'd1);
    bitc = 32;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    wr_reg(3'd4, 8'd1);
    wr_reg(3'd2, 8'h0C);
    t_tx_basic();
    t_tx_nine();
    t_sclk_pol();
    t_tx_b2b();
    t_tx_gate();
    t_rx_basic();
    t_rx_order();
    t_rx_nine();
    t_overrun();
    t_framing();
    t_glitch();
    t_rate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule